// File: doc/BRIEF.md
# Two-Stage Generic Watchdog

This block watches a 64-bit free-running system count and raises an alarm in two steps when software stops servicing it. Software programs a timeout of up to 48 bits in counter ticks and sets the enable bit. Every servicing action loads a compare value equal to the current count plus the timeout. If the count reaches that compare value, the first stage fires: a status flag is set, the interrupt line goes high, and the compare value is moved forward by one more timeout. If the count reaches the new compare value before any servicing, the second stage fires and a reset request goes high.

Register access uses a plain single-cycle port. The request is taken in the cycle where `bus_req` is high, a write takes effect at that clock edge, and read data is valid combinationally in the same cycle. There is no back-pressure, because every access completes in one cycle. `bus_frame` chooses between the service frame (0) and the control frame (1). The counter rate comes from whatever drives `sys_cnt`. All timeouts are expressed in ticks of that count, so the same block serves any tick rate.

Top module: `twostage_wdog`

## Requirements
- R1: The timeout is 48 bits wide. Control offset 0x008 holds bits 31:0 and control offset 0x00C holds bits 47:32, taken from the low 16 bits of the written word. Bits 31:16 of a write to 0x00C are dropped and read back as zero.
- R2: When enabled, the first stage fires when the count reaches the compare value while the first-stage flag is clear. Firing sets the first-stage flag (status bit 1), raises `wdt_irq`, and loads compare = count + timeout. `wdt_irq` then stays high until a servicing write.
- R3: A write of any data to service-frame offset 0x000 clears both stage flags and drops `wdt_irq` and `wdt_rst_req`. If enabled, it also loads compare = count + timeout. A read of that offset returns zero and changes nothing.
- R4: At control offset 0x000, bit 0 (enable) is the only writable bit. Bit 1 is the first-stage flag and bit 2 is the second-stage flag; both are read-only. A write to this offset clears both flags, drops `wdt_irq`, and with the new enable performs the reload of R3.
- R5: A write to either timeout word clears both flags, drops the interrupt, and reloads compare = count + new timeout.
- R6: If the count reaches the compare value while the first-stage flag is set, the second-stage flag is set and `wdt_rst_req` rises. The compare value does not move. Both outputs then hold until a servicing write.
- R7: While enable is 0, no expiry is detected, both outputs stay low, and servicing writes do not load the compare value.
- R8: If a servicing write and an expiry fall on the same clock edge, the write wins. The flags end clear and the compare value is count + timeout.
- R9: The compare value can be read and written directly at control offsets 0x010 (bits 31:0) and 0x014 (bits 63:32). Such a write does not touch the flags or the interrupt.
- R10: Offset 0xFCC in both frames reads the identification value, and writes to it are ignored. Misaligned or undefined offsets read zero and ignore writes.
- R11: Reset clears the enable bit, both flags, both timeout words and the compare value, and both outputs are low.
- R12: Expiry is a greater-or-equal test, so a count that has already passed the compare value still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = service frame, 1 = control frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| wdt_irq | output | 1 | First-stage interrupt, level |
| wdt_rst_req | output | 1 | Second-stage reset request, level |

## Verification
A servicing write can land on the same clock edge where the count meets the compare value. Both then try to update the stage flags and the compare register. The bench provokes this by setting `sys_cnt` exactly to the compare value in the cycle where it issues a service-frame write. It then checks that the interrupt stays low, the status reads back enabled with both flags clear, and the compare value equals the count plus the timeout rather than a rearm result. A direct compare write is also placed in the cycle after a first-stage expiry, to show that it keeps the flag set while replacing the compare value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 12;

  // control frame offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TMO_LO = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TMO_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 12'h014;
  // both frames
  localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'hFCC;
  // service frame
  localparam logic [ADDR_W-1:0] OFS_SVC    = 12'h000;

  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_ST1 = 1;
  localparam int unsigned BIT_ST2 = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TMO_LO,
    SEL_TMO_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_IDENT,
    SEL_SVC
  } reg_sel_e;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
(
  input  logic              frame,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (frame) begin
        case (addr)
          OFS_CTRL:   sel = SEL_CTRL;
          OFS_TMO_LO: sel = SEL_TMO_LO;
          OFS_TMO_HI: sel = SEL_TMO_HI;
          OFS_CMP_LO: sel = SEL_CMP_LO;
          OFS_CMP_HI: sel = SEL_CMP_HI;
          OFS_IDENT:  sel = SEL_IDENT;
          default:    sel = SEL_NONE;
        endcase
      end else begin
        case (addr)
          OFS_SVC:   sel = SEL_SVC;
          OFS_IDENT: sel = SEL_IDENT;
          default:   sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_stage,
  output logic st1,
  output logic st2,
  output logic rearm
);
  // a servicing write takes priority over an expiry on the same edge
  assign rearm = hit && !st1 && !clr_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 1'b0;
      st2 <= 1'b0;
    end else if (clr_stage) begin
      st1 <= 1'b0;
      st2 <= 1'b0;
    end else if (hit) begin
      if (!st1) st1 <= 1'b1;
      else      st2 <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned TMO_W  = 48,
  parameter logic [31:0] ID_VAL = 32'h0001_5A3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              rearm,
  input  logic              st1,
  input  logic              st2,
  output logic              en,
  output logic [CNT_W-1:0]  cmp,
  output logic              clr_stage,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned TMO_HI_W = TMO_W - WORD_W;

  logic                wr, rd;
  logic                en_d;
  logic [WORD_W-1:0]   tmo_lo_q, tmo_lo_d;
  logic [TMO_HI_W-1:0] tmo_hi_q, tmo_hi_d;
  logic [CNT_W-1:0]    reload_val;

  assign wr = req && we;
  assign rd = req && !we;
  assign clr_stage = wr && (sel inside {SEL_CTRL, SEL_TMO_LO, SEL_TMO_HI, SEL_SVC});

  always_comb begin
    en_d     = en;
    tmo_lo_d = tmo_lo_q;
    tmo_hi_d = tmo_hi_q;
    if (wr && sel == SEL_CTRL)   en_d     = wdata[BIT_EN];
    if (wr && sel == SEL_TMO_LO) tmo_lo_d = wdata;
    if (wr && sel == SEL_TMO_HI) tmo_hi_d = wdata[TMO_HI_W-1:0];
  end

  assign reload_val = sys_cnt + CNT_W'({tmo_hi_d, tmo_lo_d});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      tmo_lo_q <= '0;
      tmo_hi_q <= '0;
      cmp      <= '0;
    end else begin
      en       <= en_d;
      tmo_lo_q <= tmo_lo_d;
      tmo_hi_q <= tmo_hi_d;
      if (wr && sel == SEL_CMP_LO)            cmp[WORD_W-1:0]     <= wdata;
      else if (wr && sel == SEL_CMP_HI)       cmp[CNT_W-1:WORD_W] <= wdata;
      else if ((clr_stage && en_d) || rearm)  cmp                 <= reload_val;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_CTRL: begin
          rdata[BIT_EN]  = en;
          rdata[BIT_ST1] = st1;
          rdata[BIT_ST2] = st2;
        end
        SEL_TMO_LO: rdata = tmo_lo_q;
        SEL_TMO_HI: rdata = WORD_W'(tmo_hi_q);
        SEL_CMP_LO: rdata = cmp[WORD_W-1:0];
        SEL_CMP_HI: rdata = cmp[CNT_W-1:WORD_W];
        SEL_IDENT:  rdata = ID_VAL;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned TMO_W  = 48,
  parameter logic [31:0] ID_VAL = 32'h0001_5A3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  reg_sel_e         sel;
  logic             ctl_en, clr_stage, rearm, hit, st1, st2;
  logic [CNT_W-1:0] cmp_val;

  wdog_decode u_dec (
    .frame (bus_frame),
    .addr  (bus_addr),
    .sel   (sel)
  );

  wdog_regs #(.TMO_W(TMO_W), .ID_VAL(ID_VAL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .we        (bus_we),
    .sel       (sel),
    .wdata     (bus_wdata),
    .sys_cnt   (sys_cnt),
    .rearm     (rearm),
    .st1       (st1),
    .st2       (st2),
    .en        (ctl_en),
    .cmp       (cmp_val),
    .clr_stage (clr_stage),
    .rdata     (bus_rdata)
  );

  // greater-or-equal so a count already past the compare still fires
  assign hit = ctl_en && (sys_cnt >= cmp_val);

  wdog_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .clr_stage (clr_stage),
    .st1       (st1),
    .st2       (st2),
    .rearm     (rearm)
  );

  assign wdt_irq     = st1;
  assign wdt_rst_req = st2;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_en,
  input logic clr_stage,
  input logic wdt_irq,
  input logic wdt_rst_req
);
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (!wdt_irq && !wdt_rst_req));

  assert_irq_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq && !clr_stage) |=> wdt_irq);

  assert_rst_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_req && !clr_stage) |=> wdt_rst_req);

  assert_rst_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> wdt_irq);

  assert_service_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stage |=> (!wdt_irq && !wdt_rst_req));
endmodule

bind twostage_wdog wdog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_en      (ctl_en),
  .clr_stage   (clr_stage),
  .wdt_irq     (wdt_irq),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/twostage_wdog_tb_top.sv
module twostage_wdog_tb_top;
  localparam logic [31:0] TB_ID = 32'h00C0_FFEE;
  localparam int NVEC = 21;

  typedef struct packed {
    logic        frm;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] cnt;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  // frame 1 = control, 0 = service
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 12'h000, 32'h0,         32'd1000, 32'h0,        8'd11}, // R11 status after reset
    '{1'b1, 1'b0, 12'hFCC, 32'h0,         32'd1000, TB_ID,        8'd10}, // R10 id control frame
    '{1'b0, 1'b0, 12'hFCC, 32'h0,         32'd1000, TB_ID,        8'd10}, // R10 id service frame
    '{1'b1, 1'b1, 12'h00C, 32'hFFFF_1234, 32'd1000, 32'h0,        8'd1},
    '{1'b1, 1'b0, 12'h00C, 32'h0,         32'd1000, 32'h0000_1234, 8'd1}, // R1 upper bits dropped
    '{1'b1, 1'b1, 12'h008, 32'h10,        32'd1000, 32'h0,        8'd5},
    '{1'b1, 1'b0, 12'h008, 32'h0,         32'd1000, 32'h10,       8'd5},  // R5 low word
    '{1'b0, 1'b0, 12'h000, 32'h0,         32'd1000, 32'h0,        8'd3},  // R3 service read zero
    '{1'b1, 1'b1, 12'h010, 32'hABCD,      32'd1000, 32'h0,        8'd9},
    '{1'b1, 1'b0, 12'h010, 32'h0,         32'd1000, 32'hABCD,     8'd9},  // R9 direct compare
    '{1'b1, 1'b1, 12'h000, 32'hFFFF_FFFF, 32'd1000, 32'h0,        8'd4},
    '{1'b1, 1'b0, 12'h000, 32'h0,         32'd1000, 32'h1,        8'd4},  // R4 only enable
    '{1'b1, 1'b0, 12'h010, 32'h0,         32'd1000, 32'h3F8,      8'd4},  // R4 reload low
    '{1'b1, 1'b0, 12'h014, 32'h0,         32'd1000, 32'h1234,     8'd1},  // R1 48-bit reach
    '{1'b1, 1'b0, 12'h040, 32'h0,         32'd1000, 32'h0,        8'd10}, // R10 undefined
    '{1'b1, 1'b1, 12'h011, 32'h5,         32'd1000, 32'h0,        8'd10},
    '{1'b1, 1'b0, 12'h010, 32'h0,         32'd1000, 32'h3F8,      8'd10}, // R10 misaligned ignored
    '{1'b1, 1'b1, 12'hFCC, 32'h0,         32'd1000, 32'h0,        8'd10},
    '{1'b1, 1'b0, 12'hFCC, 32'h0,         32'd1000, TB_ID,        8'd10}, // R10 id read-only
    '{1'b1, 1'b1, 12'h00C, 32'h0,         32'd1000, 32'h0,        8'd5},
    '{1'b1, 1'b0, 12'h014, 32'h0,         32'd1000, 32'h0,        8'd5}   // R5 new timeout reload
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_rst_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  twostage_wdog #(.ID_VAL(TB_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .bus_req(bus_req), .bus_we(bus_we), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic frm, input logic we, input logic [11:0] a,
                    input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_frame = frm; bus_addr = a; bus_wdata = d;
    #2 rd = bus_rdata;
    @(posedge clk);
    #1 bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic frm, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    op(frm, 1'b1, a, d, dummy);
  endtask

  task automatic rchk(input string tag, input logic frm, input logic [11:0] a,
                      input logic [31:0] exp);
    logic [31:0] v;
    op(frm, 1'b0, a, 32'h0, v);
    chk(tag, v, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
  endtask

  initial begin
    do_reset();
    sys_cnt = 64'd1000;
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      sys_cnt = {32'h0, VEC[i].cnt};
      op(VEC[i].frm, VEC[i].we, VEC[i].addr, VEC[i].wd, v);
      if (!VEC[i].we) chk($sformatf("R%0d vec%0d", VEC[i].rq, i), v, VEC[i].exp);
    end

    // directed tests
    do_reset();
    chk("R11 irq after reset", wdt_irq, 0);
    chk("R11 rst_req after reset", wdt_rst_req, 0);
    sys_cnt = 64'd100;
    wr(1'b1, 12'h008, 32'h20);
    wr(1'b1, 12'h000, 32'h1);
    rchk("R4 enable reload", 1'b1, 12'h010, 32'd132);
    sys_cnt = 64'd131; tick();
    chk("R12 not yet expired", wdt_irq, 0);
    sys_cnt = 64'd132; tick();
    chk("R2 first stage irq", wdt_irq, 1);
    chk("R2 no reset yet", wdt_rst_req, 0);
    rchk("R2 status flag", 1'b1, 12'h000, 32'h3);
    rchk("R2 rearm compare", 1'b1, 12'h010, 32'd164);
    sys_cnt = 64'd200; tick();
    chk("R6 reset request", wdt_rst_req, 1);
    rchk("R6 status both flags", 1'b1, 12'h000, 32'h7);
    rchk("R6 compare unchanged", 1'b1, 12'h010, 32'd164);
    sys_cnt = 64'd300;
    wr(1'b0, 12'h000, 32'hDEAD_BEEF);
    chk("R3 service clears irq", wdt_irq, 0);
    chk("R3 service clears rst_req", wdt_rst_req, 0);
    rchk("R3 status after service", 1'b1, 12'h000, 32'h1);
    rchk("R3 reload compare", 1'b1, 12'h010, 32'd332);
    // R8: expiry and service write on the same edge
    sys_cnt = 64'd332;
    wr(1'b0, 12'h000, 32'h0);
    chk("R8 service wins irq", wdt_irq, 0);
    rchk("R8 status", 1'b1, 12'h000, 32'h1);
    rchk("R8 compare", 1'b1, 12'h010, 32'd364);
    // R5: timeout write clears stage
    sys_cnt = 64'd364; tick();
    chk("R5 setup irq", wdt_irq, 1);
    sys_cnt = 64'd370;
    wr(1'b1, 12'h008, 32'h40);
    chk("R5 timeout write clears irq", wdt_irq, 0);
    rchk("R5 new timeout compare", 1'b1, 12'h010, 32'd434);
    // R4: control write clears stage
    sys_cnt = 64'd434; tick();
    chk("R4 setup irq", wdt_irq, 1);
    sys_cnt = 64'd440;
    wr(1'b1, 12'h000, 32'h1);
    chk("R4 control write clears irq", wdt_irq, 0);
    rchk("R4 control reload", 1'b1, 12'h010, 32'd504);
    // R7: disabled
    wr(1'b1, 12'h000, 32'h0);
    sys_cnt = 64'd100000;
    repeat (3) tick();
    chk("R7 irq low when off", wdt_irq, 0);
    chk("R7 rst_req low when off", wdt_rst_req, 0);
    rchk("R7 status off", 1'b1, 12'h000, 32'h0);
    rchk("R7 no reload when off", 1'b1, 12'h010, 32'd504);
    // R9: direct compare write keeps stage
    sys_cnt = 64'd1000;
    wr(1'b1, 12'h000, 32'h1);
    sys_cnt = 64'd1064; tick();
    chk("R9 setup irq", wdt_irq, 1);
    wr(1'b1, 12'h010, 32'd2000);
    chk("R9 irq kept", wdt_irq, 1);
    rchk("R9 status kept", 1'b1, 12'h000, 32'h3);
    rchk("R9 compare written", 1'b1, 12'h010, 32'd2000);
    // R12: count already past compare
    sys_cnt = 64'd5000; tick();
    chk("R12 late expiry second stage", wdt_rst_req, 1);
    // R11: reset mid-run
    do_reset();
    chk("R11 irq cleared", wdt_irq, 0);
    chk("R11 rst_req cleared", wdt_rst_req, 0);
    rchk("R11 status cleared", 1'b1, 12'h000, 32'h0);
    rchk("R11 timeout cleared", 1'b1, 12'h008, 32'h0);
    rchk("R11 compare cleared", 1'b1, 12'h010, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule